// File: doc/BRIEF.md
# Configuration Header Identity and Command Register

This block holds the first two configuration dwords of a PCI function. Dword 0 returns the vendor and device identity. Dword 1 holds the Command register in its low half, and its upper half reads as zero here. The vendor identity is fixed. The device identity is patched after every hardware reset from one word of a serial EEPROM. A short preload sequence issues a single word-read request and waits for the response. It rejects blank (0000h) or erased (FFFFh) words and also gives up after a bounded wait. Any of these three outcomes leaves the hardwired default in place.

Configuration accesses carry a dword index, four byte enables and 32-bit write data. A read returns its data one cycle after it is accepted, flagged by a valid pulse. `cfg_ready` stays low until the preload has finished, and no access is taken before then. The writable Command bits leave the block as separate level outputs. The rest of the function uses them to gate memory decode, I/O decode, bus mastering and error reporting.

Top module: `pcicfg_idcmd`

## Requirements
- R1: A read of dword 0 returns 8086h in bits 15:0 at all times after the preload.
- R2: After reset release the block raises `ee_req` with `ee_addr` = 23h exactly once. If the response word is neither 0000h nor FFFFh, it becomes the device identity, which is read back in dword 0 bits 31:16.
- R3: A response word of 0000h or FFFFh is discarded, and the device identity stays at 2449h.
- R4: `ee_req` stays high for at most 1024 consecutive cycles. A response in the 1024th cycle is still taken. With no response by then, the request is withdrawn and the identity stays 2449h.
- R5: `cfg_ready` is low from reset until the preload ends and high from then on. Reads and writes presented while it is low are not taken: they give no `cfg_rvalid` and change no Command bit.
- R6: Reset clears the Command register to 0000h. A read of dword 1 returns {16'h0000, command}.
- R7: Command bits 8, 6, 4, 2, 1 and 0 are writable. Byte enable 0 governs bits 7:0 and byte enable 1 governs bits 15:8 of a dword-1 write. Disabled lanes keep their value.
- R8: Command bits 15:9, 7, 5 and 3 always read zero, whatever is written.
- R9: Writes to dword 0, writes to byte lanes 2–3 of dword 1, and writes to any other dword are accepted and have no effect.
- R10: The outputs carry the Command bits as follows: `cmd_io_en` = bit 0, `cmd_mem_en` = bit 1, `cmd_bm_en` = bit 2, `cmd_mwi_en` = bit 4, `cmd_perr_resp` = bit 6, `cmd_serr_en` = bit 8. They take a new value on the edge that accepts the write.
- R11: `cfg_rvalid` pulses for exactly the one cycle after an accepted read, and `cfg_rdata` holds the data in that cycle. Dwords 2 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_req | output | 1 | EEPROM word-read request, held until response or timeout |
| ee_addr | output | 8 | EEPROM word address of the identity word |
| ee_ack | input | 1 | EEPROM response strobe |
| ee_rdata | input | 16 | EEPROM response word |
| cfg_rd | input | 1 | Configuration read request |
| cfg_wr | input | 1 | Configuration write request |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_ready | output | 1 | Block accepts accesses (preload finished) |
| cfg_rdata | output | 32 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| cmd_serr_en | output | 1 | System error reporting enable |
| cmd_perr_resp | output | 1 | Parity error response enable |
| cmd_mwi_en | output | 1 | Memory write and invalidate enable |
| cmd_bm_en | output | 1 | Bus master enable |
| cmd_mem_en | output | 1 | Memory space decode enable |
| cmd_io_en | output | 1 | I/O space decode enable |

## Verification
On every cycle, the assertions check several properties. A pending EEPROM request never coexists with `cfg_ready`, and `cfg_ready` never falls. The request never outlives its time budget. Read valid only follows an accepted read. Dword-0 reads always show the fixed vendor value and a device identity that is never blank or erased. Dword-1 reads never show a hardwired bit set. The enable outputs hold still without an accepted write. Only the bench's scenarios can show that the right EEPROM word lands in the identity register, and that the default survives a blank word, an erased word and a silent EEPROM. They also show that the 1024th-cycle response is still taken, and which byte lane moves which Command bit.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  typedef enum logic [1:0] {
    LD_START = 2'd0,
    LD_WAIT  = 2'd1,
    LD_DONE  = 2'd2
  } ld_state_e;

  // Command bit positions consumed by decode and master logic
  localparam int CMD_IO   = 0;
  localparam int CMD_MEM  = 1;
  localparam int CMD_BM   = 2;
  localparam int CMD_MWI  = 4;
  localparam int CMD_PERR = 6;
  localparam int CMD_SERR = 8;

  localparam logic [15:0] CMD_WMASK = 16'h0157;

  localparam logic [15:0] ID_BLANK  = 16'h0000;
  localparam logic [15:0] ID_ERASED = 16'hFFFF;

endpackage

// File: rtl/pcicfg_idload.sv
module pcicfg_idload
  import pcicfg_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  ID_ADDR = 8'h23,
  parameter logic [15:0] DFLT_ID = 16'h2449,
  parameter int          TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ee_req,
  output logic [ADDR_W-1:0] ee_addr,
  input  logic              ee_ack,
  input  logic [15:0]       ee_rdata,
  output logic [15:0]       dev_id,
  output logic              load_done
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  ld_state_e        st_q;
  logic [CNT_W-1:0] wait_q;
  logic             word_ok;

  assign word_ok = (ee_rdata != ID_BLANK) && (ee_rdata != ID_ERASED);
  assign ee_addr = ADDR_W'(ID_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LD_START;
      wait_q    <= '0;
      ee_req    <= 1'b0;
      load_done <= 1'b0;
      dev_id    <= DFLT_ID;
    end else begin
      case (st_q)
        LD_START: begin
          ee_req <= 1'b1;
          wait_q <= '0;
          st_q   <= LD_WAIT;
        end
        LD_WAIT: begin
          if (ee_ack) begin
            if (word_ok) dev_id <= ee_rdata;
            ee_req    <= 1'b0;
            load_done <= 1'b1;
            st_q      <= LD_DONE;
          end else if (wait_q == CNT_LAST) begin
            ee_req    <= 1'b0;
            load_done <= 1'b1;
            st_q      <= LD_DONE;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: begin
          ee_req    <= 1'b0;
          load_done <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pcicfg_cmdreg.sv
module pcicfg_cmdreg #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] WMASK = 16'h0157
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [WIDTH/8-1:0]     be,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WIDTH-1:0]       cmd
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (WMASK[i]) begin : g_rw
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                  bit_q <= 1'b0;
        else if (wr_en && be[i/8]) bit_q <= wdata[i];
      end
      assign cmd[i] = bit_q;
    end else begin : g_zero
      assign cmd[i] = 1'b0;
    end
  end

endmodule

// File: rtl/pcicfg_rdport.sv
module pcicfg_rdport #(
  parameter int          DW_W = 6,
  parameter logic [15:0] VID  = 16'h8086
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [DW_W-1:0] dw,
  input  logic [15:0]     dev_id,
  input  logic [15:0]     cmd,
  output logic [31:0]     rdata,
  output logic            rvalid
);

  logic [31:0] sel;

  always_comb begin
    case (dw)
      DW_W'(0): sel = {dev_id, VID};
      DW_W'(1): sel = {16'h0000, cmd};
      default:  sel = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= 32'h0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end

endmodule

// File: rtl/pcicfg_idcmd.sv
module pcicfg_idcmd
  import pcicfg_pkg::*;
#(
  parameter int          EE_ADDR_W  = 8,
  parameter logic [7:0]  ID_WORD    = 8'h23,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [15:0] DEVICE_DFL = 16'h2449,
  parameter int          EE_TIMEOUT = 1024,
  parameter int          DW_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 ee_req,
  output logic [EE_ADDR_W-1:0] ee_addr,
  input  logic                 ee_ack,
  input  logic [15:0]          ee_rdata,
  input  logic                 cfg_rd,
  input  logic                 cfg_wr,
  input  logic [DW_W-1:0]      cfg_dw,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic                 cfg_ready,
  output logic [31:0]          cfg_rdata,
  output logic                 cfg_rvalid,
  output logic                 cmd_serr_en,
  output logic                 cmd_perr_resp,
  output logic                 cmd_mwi_en,
  output logic                 cmd_bm_en,
  output logic                 cmd_mem_en,
  output logic                 cmd_io_en
);

  localparam logic [DW_W-1:0] CMD_DW = DW_W'(1);

  logic [15:0] dev_id;
  logic [15:0] cmd;
  logic        load_done;
  logic        rd_go;
  logic        wr_go;
  logic        unused_upper;

  assign unused_upper = ^{cfg_wdata[31:16], cfg_be[3:2]};

  pcicfg_idload #(
    .ADDR_W  (EE_ADDR_W),
    .ID_ADDR (ID_WORD),
    .DFLT_ID (DEVICE_DFL),
    .TIMEOUT (EE_TIMEOUT)
  ) u_load (
    .clk       (clk),
    .rst       (rst),
    .ee_req    (ee_req),
    .ee_addr   (ee_addr),
    .ee_ack    (ee_ack),
    .ee_rdata  (ee_rdata),
    .dev_id    (dev_id),
    .load_done (load_done)
  );

  assign cfg_ready = load_done;
  assign rd_go     = cfg_rd && load_done;
  assign wr_go     = cfg_wr && load_done && (cfg_dw == CMD_DW);

  pcicfg_cmdreg #(
    .WIDTH (16),
    .WMASK (CMD_WMASK)
  ) u_cmd (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_go),
    .be    (cfg_be[1:0]),
    .wdata (cfg_wdata[15:0]),
    .cmd   (cmd)
  );

  pcicfg_rdport #(
    .DW_W (DW_W),
    .VID  (VENDOR_ID)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_go),
    .dw     (cfg_dw),
    .dev_id (dev_id),
    .cmd    (cmd),
    .rdata  (cfg_rdata),
    .rvalid (cfg_rvalid)
  );

  assign cmd_io_en     = cmd[CMD_IO];
  assign cmd_mem_en    = cmd[CMD_MEM];
  assign cmd_bm_en     = cmd[CMD_BM];
  assign cmd_mwi_en    = cmd[CMD_MWI];
  assign cmd_perr_resp = cmd[CMD_PERR];
  assign cmd_serr_en   = cmd[CMD_SERR];

endmodule

// File: rtl/pcicfg_idcmd_chk.sv
module pcicfg_idcmd_chk #(
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter int          EE_TIMEOUT = 1024,
  parameter int          DW_W       = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            ee_req,
  input logic            cfg_rd,
  input logic            cfg_wr,
  input logic [DW_W-1:0] cfg_dw,
  input logic            cfg_ready,
  input logic [31:0]     cfg_rdata,
  input logic            cfg_rvalid,
  input logic [5:0]      cmd_outs
);

  localparam int RW = $clog2(EE_TIMEOUT + 1) + 1;
  localparam logic [15:0] HARD_ZERO = 16'hFEA8;

  logic [RW-1:0] req_run;

  always_ff @(posedge clk) begin
    if (rst)         req_run <= '0;
    else if (ee_req) req_run <= req_run + 1'b1;
    else             req_run <= '0;
  end

  assert_req_excl_ready_R5: assert property (@(posedge clk) disable iff (rst)
    ee_req |-> !cfg_ready);

  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> cfg_ready);

  assert_req_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    ee_req |-> (req_run < RW'(EE_TIMEOUT)));

  assert_rvalid_cause_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> $past(cfg_rd && cfg_ready));

  assert_vendor_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_rvalid && $past(cfg_dw) == DW_W'(0)) |-> (cfg_rdata[15:0] == VENDOR_ID));

  assert_id_not_blank_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rvalid && $past(cfg_dw) == DW_W'(0)) |->
      (cfg_rdata[31:16] != 16'h0000 && cfg_rdata[31:16] != 16'hFFFF));

  assert_hardwired_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rvalid && $past(cfg_dw) == DW_W'(1)) |->
      ((cfg_rdata[15:0] & HARD_ZERO) == 16'h0 && cfg_rdata[31:16] == 16'h0));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_wr && cfg_ready) |-> $stable(cmd_outs));

endmodule

bind pcicfg_idcmd pcicfg_idcmd_chk #(
  .VENDOR_ID  (VENDOR_ID),
  .EE_TIMEOUT (EE_TIMEOUT),
  .DW_W       (DW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ee_req     (ee_req),
  .cfg_rd     (cfg_rd),
  .cfg_wr     (cfg_wr),
  .cfg_dw     (cfg_dw),
  .cfg_ready  (cfg_ready),
  .cfg_rdata  (cfg_rdata),
  .cfg_rvalid (cfg_rvalid),
  .cmd_outs   ({cmd_serr_en, cmd_perr_resp, cmd_mwi_en, cmd_bm_en, cmd_mem_en, cmd_io_en})
);

// File: tb/pcicfg_idcmd_tb.sv
`timescale 1ns/1ps
module pcicfg_idcmd_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ee_req;
  logic [7:0]  ee_addr;
  logic        ee_ack = 1'b0;
  logic [15:0] ee_rdata = 16'h0;
  logic        cfg_rd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_ready;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        cmd_serr_en, cmd_perr_resp, cmd_mwi_en, cmd_bm_en, cmd_mem_en, cmd_io_en;

  int checks = 0;
  int fails  = 0;
  bit          rsp_on = 1'b1;
  int          rsp_delay = 0;
  logic [15:0] rsp_data = 16'h0;
  int          wait_n = 0;
  int          req_cycles = 0;
  int          req_rises = 0;
  int          bad_addr = 0;
  logic        req_prev = 1'b0;
  logic [15:0] model_cmd = 16'h0;
  logic [31:0] rd_val;

  always #2.5 clk = ~clk;

  pcicfg_idcmd u_dut (
    .clk(clk), .rst(rst), .ee_req(ee_req), .ee_addr(ee_addr),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
    .cmd_mwi_en(cmd_mwi_en), .cmd_bm_en(cmd_bm_en), .cmd_mem_en(cmd_mem_en),
    .cmd_io_en(cmd_io_en)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // EEPROM model and request monitor
  initial begin
    forever begin
      @(negedge clk);
      ee_ack = 1'b0;
      if (rst) begin
        wait_n = 0;
        req_prev = 1'b0;
      end else begin
        if (ee_req) begin
          req_cycles++;
          if (!req_prev) req_rises++;
          if (ee_addr !== 8'h23) bad_addr++;
          if (rsp_on) begin
            if (wait_n == rsp_delay) begin
              ee_ack = 1'b1;
              ee_rdata = rsp_data;
            end
            wait_n++;
          end
        end
        req_prev = ee_req;
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs_of(input logic [15:0] m);
    return {m[8], m[6], m[4], m[2], m[1], m[0]};
  endfunction

  task automatic chk_outs(input string tag);
    chk(tag, {26'h0, cmd_serr_en, cmd_perr_resp, cmd_mwi_en, cmd_bm_en, cmd_mem_en, cmd_io_en},
        {26'h0, outs_of(model_cmd)});
  endtask

  task automatic cfg_read(input logic [5:0] dw, output logic [31:0] val);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw = dw;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk("R11 rvalid", {31'h0, cfg_rvalid}, 32'h1);
    val = cfg_rdata;
    @(negedge clk);
    chk("R11 rvalid pulse", {31'h0, cfg_rvalid}, 32'h0);
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (dw == 6'd1) begin
      if (be[0]) model_cmd[7:0]  = d[7:0] & 8'h57;
      if (be[1]) model_cmd[15:8] = d[15:8] & 8'h01;
    end
  endtask

  task automatic start_boot(input bit on, input int dly, input logic [15:0] data);
    @(negedge clk);
    rst = 1'b1;
    rsp_on = on; rsp_delay = dly; rsp_data = data;
    repeat (3) @(negedge clk);
    req_cycles = 0; req_rises = 0; bad_addr = 0;
    model_cmd = 16'h0;
    chk("R6 reset ready", {31'h0, cfg_ready}, 32'h0);
    chk("R6 reset rvalid", {31'h0, cfg_rvalid}, 32'h0);
    chk_outs("R6 reset outs");
    rst = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000 && !cfg_ready; i++) @(negedge clk);
  endtask

  task automatic boot_case(input bit on, input int dly, input logic [15:0] data);
    logic [15:0] exp_id;
    exp_id = (on && data != 16'h0000 && data != 16'hFFFF) ? data : 16'h2449;
    start_boot(on, dly, data);
    wait_ready();
    chk("R5 ready", {31'h0, cfg_ready}, 32'h1);
    chk("R2 one request", req_rises, 1);
    chk("R2 word address", bad_addr, 0);
    chk("R4 request length", req_cycles, on ? dly + 1 : 1024);
    cfg_read(6'd0, rd_val);
    chk("R1 vendor", {16'h0, rd_val[15:0]}, 32'h8086);
    if (exp_id == 16'h2449) chk("R3 default id", {16'h0, rd_val[31:16]}, {16'h0, exp_id});
    else                    chk("R2 loaded id",  {16'h0, rd_val[31:16]}, {16'h0, exp_id});
  endtask

  initial begin
    // identity preload variants
    boot_case(1'b1, 3,    16'h1234);
    boot_case(1'b1, 0,    16'h0000);
    boot_case(1'b1, 5,    16'hFFFF);
    boot_case(1'b1, 10,   16'h0001);
    boot_case(1'b1, 1,    16'hFFFE);
    boot_case(1'b1, 1023, 16'hBEEF);
    boot_case(1'b0, 0,    16'h5555);

    // R5: accesses during preload are not taken (silent EEPROM)
    start_boot(1'b0, 0, 16'h0);
    repeat (10) @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = 6'd1; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b1; cfg_dw = 6'd1;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk("R5 no rvalid while loading", {31'h0, cfg_rvalid}, 32'h0);
    chk("R5 not ready while loading", {31'h0, cfg_ready}, 32'h0);
    chk_outs("R5 write dropped while loading");
    wait_ready();
    cfg_read(6'd1, rd_val);
    chk("R6 command after stalled write", rd_val, 32'h0);
    cfg_read(6'd0, rd_val);
    chk("R4 timeout id", {16'h0, rd_val[31:16]}, 32'h2449);

    // R7/R8/R10: low byte lane sweep
    for (int v = 0; v < 256; v++) begin
      cfg_write(6'd1, 4'b0001, {24'h0, v[7:0]});
      chk_outs("R10 outs low lane");
      cfg_read(6'd1, rd_val);
      chk("R7 R8 low lane readback", rd_val, {16'h0, model_cmd});
    end
    // high byte lane sweep
    for (int v = 0; v < 256; v++) begin
      cfg_write(6'd1, 4'b0010, {16'h0, v[7:0], 8'h0});
      chk_outs("R10 outs high lane");
      cfg_read(6'd1, rd_val);
      chk("R7 R8 high lane readback", rd_val, {16'h0, model_cmd});
    end
    // byte-enable sweep, R9 upper lanes have no effect
    for (int b = 0; b < 16; b++) begin
      cfg_write(6'd1, 4'hF, 32'h0);
      cfg_write(6'd1, b[3:0], 32'hFFFF_FFFF);
      chk_outs("R7 outs by enable");
      cfg_read(6'd1, rd_val);
      chk("R7 R9 enable readback", rd_val, {16'h0, model_cmd});
    end

    // R9: writes elsewhere
    cfg_write(6'd1, 4'hF, 32'h0000_0155);
    cfg_write(6'd0, 4'hF, 32'h0000_0000);
    cfg_write(6'd2, 4'hF, 32'hFFFF_FFFF);
    cfg_write(6'd63, 4'hF, 32'h0);
    chk_outs("R9 outs unchanged");
    cfg_read(6'd0, rd_val);
    chk("R9 identity unchanged", rd_val, 32'h2449_8086);
    cfg_read(6'd1, rd_val);
    chk("R9 command unchanged", rd_val, 32'h0000_0155);

    // R11: higher dwords read zero
    for (int d = 2; d < 64; d += 7) begin
      cfg_read(d[5:0], rd_val);
      chk("R11 high dword zero", rd_val, 32'h0);
    end

    // R6: reset clears a nonzero command
    boot_case(1'b1, 2, 16'hA5A5);
    cfg_read(6'd1, rd_val);
    chk("R6 command after reset", rd_val, 32'h0);

    finish_run();
  end

endmodule